// File: doc/BRIEF.md
# Bridge Configuration Status/Command Register

This block holds one 32-bit configuration-space word for a bridge function. The word joins command controls, which software sets and clears freely, with status flags that hardware raises and software lowers by writing 1. The block watches the completion status of the bridge's outbound requests. It latches an unsupported-request result as a received master abort and a completer-abort result as a received target abort. When the bridge is built as the fabric-side port, neither abort flag is ever raised.

A level interrupt source is sampled into a read-only status bit. The legacy INTx output follows that bit unless the interrupt-off command bit is set. When system-error reporting is on in this word and an external unsupported-request reporting enable is also on, an unsupported-request completion raises a signalled-system-error flag. It also pulses a one-cycle request for a non-fatal error message. The message transport itself sits outside this block.

Configuration reads are registered: the data appears one cycle after the read strobe.

Top module: `brg_cfg_stcmd`

## Requirements
- R1: After reset, a read of the word at its offset returns 0x00100000.
- R2: A completion with status code 3'b001 (unsupported request) sets bit 29. A write to the word's offset with byte enable 3 set and data bit 29 = 1 clears it. A write with data bit 29 = 0 leaves it unchanged.
- R3: A completion with status code 3'b100 (completer abort) sets bit 28, which clears like bit 29. Codes 3'b000 and 3'b010 set nothing.
- R4: When a set event and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R5: With parameter IS_FABRIC = 1, bits 29 and 28 always read 0.
- R6: Bit 20 always reads 1. Bits 31, 27, 26:21, 18:16, 15:11, 9 and 0 always read 0, whatever is written.
- R7: Bit 19 equals the interrupt source input as sampled at the previous clock edge, for either value of bit 10.
- R8: `intx_out` is 1 exactly when bit 19 is 1 and bit 10 is 0.
- R9: Bits 10 and 8 are written from data when byte enable 1 is set. Bits 2 and 1 are written from data when byte enable 0 is set. Writes to another offset, or to a byte whose enable is clear, change nothing.
- R10: An unsupported-request completion while bit 8 and `urre_en` are both 1 sets bit 30 and drives `err_nf_req` high for exactly the following cycle. Bit 30 clears by a write of 1 under byte enable 3.
- R11: `cfg_rdata` carries the word one cycle after `cfg_rd` at the word's offset (dword compare on address bits above 1). Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Configuration byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Write byte enables |
| cfg_rdata | output | 32 | Registered read data |
| cpl_valid | input | 1 | Completion status valid |
| cpl_status | input | 3 | Completion status code |
| urre_en | input | 1 | External unsupported-request reporting enable |
| irq_src | input | 1 | Level interrupt source |
| intx_out | output | 1 | Legacy interrupt output |
| err_nf_req | output | 1 | One-cycle non-fatal error message request |

## Verification
The hardest case to reach is a hardware set and a software write-1 clear landing on the same status flag in the same cycle. A second hard case is a signalled-error event that needs two separate enables aligned with an unsupported-request completion. Directed sequences line these up exactly. Random cycles mix completion codes, write data, byte enables, stray offsets and both enables, so that these overlaps also occur by chance. A second instance built as the fabric port receives the same stimulus, which shows that its abort flags stay low while everything else still matches.

// File: rtl/brg_stcmd_pkg.sv
package brg_stcmd_pkg;

  typedef enum logic [2:0] {
    CPL_SC  = 3'b000,
    CPL_UR  = 3'b001,
    CPL_CRS = 3'b010,
    CPL_CA  = 3'b100
  } cpl_sts_e;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned B_SIG_SERR  = 30;
  localparam int unsigned B_RX_MABORT = 29;
  localparam int unsigned B_RX_TABORT = 28;
  localparam int unsigned B_CAP_LIST  = 20;
  localparam int unsigned B_IRQ_STS   = 19;
  localparam int unsigned B_IRQ_OFF   = 10;
  localparam int unsigned B_SERR_EN   = 8;
  localparam int unsigned B_BUS_MST   = 2;
  localparam int unsigned B_MEM_EN    = 1;

  localparam logic [WORD_W-1:0] LIVE_MASK =
    (32'd1 << B_SIG_SERR) | (32'd1 << B_RX_MABORT) | (32'd1 << B_RX_TABORT) |
    (32'd1 << B_CAP_LIST) | (32'd1 << B_IRQ_STS)   | (32'd1 << B_IRQ_OFF)   |
    (32'd1 << B_SERR_EN)  | (32'd1 << B_BUS_MST)   | (32'd1 << B_MEM_EN);
  localparam logic [WORD_W-1:0] RSVD_MASK = ~LIVE_MASK;

endpackage

// File: rtl/brg_cpl_decode.sv
module brg_cpl_decode #(
  parameter bit IS_FABRIC = 1'b0
) (
  input  logic       cpl_valid,
  input  logic [2:0] cpl_status,
  output logic [1:0] abort_set_o,
  output logic       ur_seen_o
);
  import brg_stcmd_pkg::*;

  logic ur_hit;
  logic ca_hit;

  assign ur_hit    = cpl_valid && (cpl_status == CPL_UR);
  assign ca_hit    = cpl_valid && (cpl_status == CPL_CA);
  assign ur_seen_o = ur_hit;

  // bit 1 -> received master abort, bit 0 -> received target abort
  if (IS_FABRIC) begin : g_fabric
    assign abort_set_o = 2'b00;
  end else begin : g_endpoint
    assign abort_set_o = {ur_hit, ca_hit};
  end

endmodule

// File: rtl/brg_sts_w1c.sv
module brg_sts_w1c #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;

    always_ff @(posedge clk) begin
      if (rst)           bit_q <= 1'b0;
      else if (set_i[i]) bit_q <= 1'b1;
      else if (clr_i[i]) bit_q <= 1'b0;
    end

    assign q_o[i] = bit_q;

    // R4
    set_prio_chk: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> q_o[i]);

    // R2
    w1c_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);

    // R2
    w1c_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
  end

endmodule

// File: rtl/brg_cmd_rw.sv
module brg_cmd_rw #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;

    always_ff @(posedge clk) begin
      if (rst)          bit_q <= 1'b0;
      else if (we_i[i]) bit_q <= d_i[i];
    end

    assign q_o[i] = bit_q;

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !we_i[i] |=> $stable(q_o[i]));
  end

endmodule

// File: rtl/brg_err_msg.sv
module brg_err_msg (
  input  logic clk,
  input  logic rst,
  input  logic ur_seen_i,
  input  logic serr_en_i,
  input  logic urre_en_i,
  output logic sse_set_o,
  output logic err_req_o
);

  assign sse_set_o = ur_seen_i && serr_en_i && urre_en_i;

  always_ff @(posedge clk) begin
    if (rst) err_req_o <= 1'b0;
    else     err_req_o <= sse_set_o;
  end

endmodule

// File: rtl/brg_cfg_stcmd.sv
module brg_cfg_stcmd #(
  parameter int               ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] REG_OFS  = 12'h004,
  parameter bit               IS_FABRIC = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [3:0]        cfg_be,
  output logic [31:0]       cfg_rdata,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_status,
  input  logic              urre_en,
  input  logic              irq_src,
  output logic              intx_out,
  output logic              err_nf_req
);
  import brg_stcmd_pkg::*;

  localparam int N_STS = 3;
  localparam int N_CMD = 4;

  logic             addr_hit;
  logic             wr_hit;
  logic             rd_hit;
  logic [1:0]       abort_set;
  logic             ur_seen;
  logic             sse_set;
  logic [N_STS-1:0] sts_set;
  logic [N_STS-1:0] sts_clr;
  logic [N_STS-1:0] sts_q;
  logic [N_CMD-1:0] cmd_we;
  logic [N_CMD-1:0] cmd_d;
  logic [N_CMD-1:0] cmd_q;
  logic             irq_q;
  logic [31:0]      word;

  assign addr_hit = (cfg_addr[ADDR_W-1:2] == REG_OFS[ADDR_W-1:2]);
  assign wr_hit   = cfg_wr && addr_hit;
  assign rd_hit   = cfg_rd && addr_hit;

  brg_cpl_decode #(.IS_FABRIC(IS_FABRIC)) u_dec (
    .cpl_valid  (cpl_valid),
    .cpl_status (cpl_status),
    .abort_set_o(abort_set),
    .ur_seen_o  (ur_seen)
  );

  brg_err_msg u_err (
    .clk      (clk),
    .rst      (rst),
    .ur_seen_i(ur_seen),
    .serr_en_i(cmd_q[2]),
    .urre_en_i(urre_en),
    .sse_set_o(sse_set),
    .err_req_o(err_nf_req)
  );

  // status order: [2] signalled error, [1] master abort, [0] target abort
  assign sts_set = {sse_set, abort_set};
  assign sts_clr = {N_STS{wr_hit && cfg_be[3]}} &
                   {cfg_wdata[B_SIG_SERR], cfg_wdata[B_RX_MABORT], cfg_wdata[B_RX_TABORT]};

  brg_sts_w1c #(.N(N_STS)) u_sts (
    .clk  (clk),
    .rst  (rst),
    .set_i(sts_set),
    .clr_i(sts_clr),
    .q_o  (sts_q)
  );

  // command order: [3] irq off, [2] serr enable, [1] bus master, [0] memory enable
  assign cmd_we = {{2{wr_hit && cfg_be[1]}}, {2{wr_hit && cfg_be[0]}}};
  assign cmd_d  = {cfg_wdata[B_IRQ_OFF], cfg_wdata[B_SERR_EN],
                   cfg_wdata[B_BUS_MST], cfg_wdata[B_MEM_EN]};

  brg_cmd_rw #(.N(N_CMD)) u_cmd (
    .clk (clk),
    .rst (rst),
    .we_i(cmd_we),
    .d_i (cmd_d),
    .q_o (cmd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_src;
  end

  assign intx_out = irq_q && !cmd_q[3];

  always_comb begin
    word              = '0;
    word[B_SIG_SERR]  = sts_q[2];
    word[B_RX_MABORT] = sts_q[1];
    word[B_RX_TABORT] = sts_q[0];
    word[B_CAP_LIST]  = 1'b1;
    word[B_IRQ_STS]   = irq_q;
    word[B_IRQ_OFF]   = cmd_q[3];
    word[B_SERR_EN]   = cmd_q[2];
    word[B_BUS_MST]   = cmd_q[1];
    word[B_MEM_EN]    = cmd_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (rd_hit) cfg_rdata <= word;
    else             cfg_rdata <= '0;
  end

  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & RSVD_MASK) == 32'd0);

  // R11
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (cfg_rdata == 32'd0));

  // R6
  cap_bit_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> cfg_rdata[B_CAP_LIST]);

  // R8
  intx_src_chk: assert property (@(posedge clk) disable iff (rst)
    intx_out |-> $past(irq_src));

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    err_nf_req |-> $past(cpl_valid && (cpl_status == CPL_UR) && urre_en));

  if (IS_FABRIC) begin : g_fab_chk
    // R5
    fab_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
      sts_q[1:0] == 2'b00);
  end

endmodule

// File: tb/brg_cfg_stcmd_tb.sv
module brg_cfg_stcmd_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_status = '0;
  logic        urre_en = 1'b0, irq_src = 1'b0;
  logic [31:0] rdata, rdata_f;
  logic        intx, intx_f, err, err_f;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit m_sse, m_ma, m_ta, m_irq, m_off, m_serr, m_bm, m_mem;
  logic [31:0] e_rd, e_rd_f;
  bit e_err;

  always #10 clk = ~clk;

  brg_cfg_stcmd #(.IS_FABRIC(1'b0)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(rdata), .cpl_valid(cpl_valid),
    .cpl_status(cpl_status), .urre_en(urre_en), .irq_src(irq_src),
    .intx_out(intx), .err_nf_req(err));

  brg_cfg_stcmd #(.IS_FABRIC(1'b1)) dut_fab_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(rdata_f), .cpl_valid(cpl_valid),
    .cpl_status(cpl_status), .urre_en(urre_en), .irq_src(irq_src),
    .intx_out(intx_f), .err_nf_req(err_f));

  function automatic logic [31:0] pack(bit fab);
    logic [31:0] w = 32'h0010_0000;
    w[30] = m_sse; w[29] = fab ? 1'b0 : m_ma; w[28] = fab ? 1'b0 : m_ta;
    w[19] = m_irq; w[10] = m_off; w[8] = m_serr; w[2] = m_bm; w[1] = m_mem;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit wr, bit rd, logic [11:0] a, logic [31:0] d, logic [3:0] be,
                     bit cv, logic [2:0] cs, bit ure, bit irq);
    bit hit, ur, ca, wb3;
    cfg_wr = wr; cfg_rd = rd; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    cpl_valid = cv; cpl_status = cs; urre_en = ure; irq_src = irq;
    @(posedge clk);
    hit = (a[11:2] == 10'd1);
    ur  = cv && (cs == 3'b001);
    ca  = cv && (cs == 3'b100);
    e_rd   = (rd && hit) ? pack(1'b0) : 32'd0;
    e_rd_f = (rd && hit) ? pack(1'b1) : 32'd0;
    e_err  = ur && m_serr && ure;
    wb3 = wr && hit && be[3];
    m_sse = e_err || (m_sse && !(wb3 && d[30]));
    m_ma  = ur    || (m_ma  && !(wb3 && d[29]));
    m_ta  = ca    || (m_ta  && !(wb3 && d[28]));
    if (wr && hit && be[1]) begin m_off = d[10]; m_serr = d[8]; end
    if (wr && hit && be[0]) begin m_bm = d[2]; m_mem = d[1]; end
    m_irq = irq;
    @(negedge clk);
    chk("R11 rdata", rdata, e_rd);
    chk("R5 fabric rdata", rdata_f, e_rd_f);
    chk("R10 err_nf_req", {31'd0, err}, {31'd0, e_err});
    chk("R8 intx_out", {31'd0, intx}, {31'd0, m_irq && !m_off});
  endtask

  task automatic rd_word(bit irq, output logic [31:0] v, output logic [31:0] vf);
    cyc(1'b0, 1'b1, 12'h004, 32'd0, 4'h0, 1'b0, 3'b000, 1'b0, irq);
    v = rdata; vf = rdata_f;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, vf;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 32'd0);
    rst = 1'b0;
    {m_sse, m_ma, m_ta, m_irq, m_off, m_serr, m_bm, m_mem} = '0;

    // R1
    rd_word(1'b0, v, vf);
    chk("R1 reset word", v, 32'h0010_0000);

    // R6 / R9 all-ones write
    cyc(1'b1, 1'b0, 12'h004, 32'hFFFF_FFFF, 4'hF, 1'b0, 3'b000, 1'b0, 1'b0);
    rd_word(1'b0, v, vf);
    chk("R6 reserved and cap bits", v, 32'h0010_0506);

    // R9 byte1 disabled
    cyc(1'b1, 1'b0, 12'h004, 32'h0, 4'b1101, 1'b0, 3'b000, 1'b0, 1'b0);
    rd_word(1'b0, v, vf);
    chk("R9 byte enable mask", v, 32'h0010_0500);
    cyc(1'b1, 1'b0, 12'h008, 32'h0, 4'hF, 1'b0, 3'b000, 1'b0, 1'b0);
    rd_word(1'b0, v, vf);
    chk("R9 other offset ignored", v, 32'h0010_0500);
    cyc(1'b0, 1'b1, 12'h00C, 32'h0, 4'h0, 1'b0, 3'b000, 1'b0, 1'b0);
    chk("R11 read other offset", rdata, 32'd0);

    // R7 / R8 irq with disable set
    cyc(1'b0, 1'b0, 12'h004, 32'h0, 4'h0, 1'b0, 3'b000, 1'b0, 1'b1);
    chk("R8 intx masked", {31'd0, intx}, 32'd0);
    rd_word(1'b1, v, vf);
    chk("R7 irq bit with disable", {31'd0, v[19]}, 32'd1);
    cyc(1'b1, 1'b0, 12'h004, 32'h0, 4'h2, 1'b0, 3'b000, 1'b0, 1'b1);
    chk("R8 intx unmasked", {31'd0, intx}, 32'd1);
    cyc(1'b0, 1'b0, 12'h004, 32'h0, 4'h0, 1'b0, 3'b000, 1'b0, 1'b0);
    chk("R7 irq drop", {31'd0, intx}, 32'd0);

    // R2 master abort, R5 fabric
    cyc(1'b0, 1'b0, 12'h004, 32'h0, 4'h0, 1'b1, 3'b001, 1'b0, 1'b0);
    rd_word(1'b0, v, vf);
    chk("R2 UR sets bit29", {31'd0, v[29]}, 32'd1);
    chk("R5 fabric bit29", {31'd0, vf[29]}, 32'd0);
    cyc(1'b1, 1'b0, 12'h004, 32'h0, 4'hF, 1'b0, 3'b000, 1'b0, 1'b0);
    rd_word(1'b0, v, vf);
    chk("R2 write 0 keeps", {31'd0, v[29]}, 32'd1);
    cyc(1'b1, 1'b0, 12'h004, 32'h2000_0000, 4'hF, 1'b0, 3'b000, 1'b0, 1'b0);
    rd_word(1'b0, v, vf);
    chk("R2 write 1 clears", {31'd0, v[29]}, 32'd0);

    // R3 target abort and non-abort codes
    cyc(1'b0, 1'b0, 12'h004, 32'h0, 4'h0, 1'b1, 3'b010, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 12'h004, 32'h0, 4'h0, 1'b1, 3'b000, 1'b0, 1'b0);
    rd_word(1'b0, v, vf);
    chk("R3 SC/CRS set nothing", v & 32'h7000_0000, 32'd0);
    cyc(1'b0, 1'b0, 12'h004, 32'h0, 4'h0, 1'b1, 3'b100, 1'b0, 1'b0);
    rd_word(1'b0, v, vf);
    chk("R3 CA sets bit28", v & 32'h7000_0000, 32'h1000_0000);
    chk("R5 fabric bit28", vf & 32'h3000_0000, 32'd0);

    // R4 set wins over clear
    cyc(1'b1, 1'b0, 12'h004, 32'h1000_0000, 4'h8, 1'b1, 3'b100, 1'b0, 1'b0);
    rd_word(1'b0, v, vf);
    chk("R4 set beats clear", {31'd0, v[28]}, 32'd1);

    // R10 signalled error: enable bit 8
    cyc(1'b1, 1'b0, 12'h004, 32'h0000_0100, 4'h2, 1'b0, 3'b000, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 12'h004, 32'h0, 4'h0, 1'b1, 3'b001, 1'b0, 1'b0);
    chk("R10 no pulse without urre", {31'd0, err}, 32'd0);
    cyc(1'b0, 1'b0, 12'h004, 32'h0, 4'h0, 1'b1, 3'b001, 1'b1, 1'b0);
    chk("R10 pulse", {31'd0, err}, 32'd1);
    cyc(1'b0, 1'b0, 12'h004, 32'h0, 4'h0, 1'b0, 3'b000, 1'b1, 1'b0);
    chk("R10 single cycle", {31'd0, err}, 32'd0);
    rd_word(1'b0, v, vf);
    chk("R10 bit30 set", {31'd0, v[30]}, 32'd1);
    cyc(1'b1, 1'b0, 12'h004, 32'h4000_0000, 4'h8, 1'b0, 3'b000, 1'b0, 1'b0);
    rd_word(1'b0, v, vf);
    chk("R10 bit30 cleared", {31'd0, v[30]}, 32'd0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [2:0]  cs;
      int pick;
      a = (($urandom % 4) == 0) ? (12'($urandom) & 12'hFFC) : 12'h004;
      pick = $urandom % 4;
      cs = (pick == 0) ? 3'b000 : (pick == 1) ? 3'b001 : (pick == 2) ? 3'b010 : 3'b100;
      cyc(($urandom % 3) == 0, ($urandom % 2) == 0, a, $urandom, 4'($urandom),
          ($urandom % 3) == 0, cs, ($urandom % 2) == 0, ($urandom % 4) != 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule